// File: doc/BRIEF.md
# Symmetrical Interleaved Three-Carrier PWM Modulator

This block drives the five switches of an interleaved, two-branch, three-port boost power stage. Each branch has a main switch, which charges the branch inductor, and a diversion switch, which steers the inductor current into the battery port. A fifth switch picks which source feeds the inductors. All five gates come from comparisons of latched duty words against triangular up/down carriers. Branch A uses carrier A. Branch B uses carrier B, which is the same triangle shifted by half a period. The input-selection switch uses a third triangle at twice the switching frequency.

In each branch the main pulse is centred on the carrier valley and the diversion pulse on the carrier peak. The two pulses of one branch therefore stay apart whenever their duties add up to no more than full scale. If a duty pair exceeds full scale, the diversion duty is trimmed and a sticky per-branch flag is raised.

A one-clock strobe marks the peak or the valley of carrier A. At that point no branch gate switches, so an ADC triggered there reads the average inductor current. Duty words take effect only at the valley of their own carrier, so a change never cuts a pulse short in the middle of a period.

Top module: `pwm3_modulator`

## Requirements
- R1: Carrier A counts 0 up to FULL and back down to 0, one step per enabled clock, with a period of 2*FULL clocks. It sits at its valley in the first enabled clock. Carrier B takes the same path but sits at its peak (FULL, about to count down) in the first enabled clock.
- R2: The selection carrier counts 0 up to FULL/2 and back, with a period of FULL clocks. Its valley falls on every valley of carrier A.
- R3: A main gate is high on rising steps where count < main duty and on falling steps where count <= main duty, giving 2*Dm clocks per period centred on the valley. A diversion gate is high on rising steps where count >= FULL - Dd and on falling steps where count > FULL - Dd, giving 2*Dd clocks centred on the peak.
- R4: The selection gate is high on rising steps where 2*count < Ds and on falling steps where 2*count <= Ds, giving Ds clocks in every FULL-clock selection period.
- R5: A duty word above FULL is treated as FULL. A duty of 0 keeps its gate low for the whole period, and a duty of FULL keeps it high.
- R6: The main gate and the diversion gate of one branch are never high in the same clock.
- R7: When a branch's clamped main and diversion duties add up to more than FULL, the diversion duty used is FULL - main. The branch's bit of overlap_err is set (bit 0 for branch A, bit 1 for branch B) and stays set until reset.
- R8: Duty words are taken only at the valley of the gate's own carrier, or on any clock while en is low. A change made in the middle of a period has no effect before the next such valley.
- R9: adc_strobe is a one-clock pulse once per carrier-A period. With smp_valley = 0 it falls on the carrier-A peak, FULL clocks after enable. With smp_valley = 1 it falls on the carrier-A valley, the first enabled clock.
- R10: In a strobe clock, none of the four branch gates has changed from the clock before.
- R11: With en low, all gates and adc_strobe are low and the carriers are held at their start phase, so enabling restarts them from that phase. A synchronous reset clears overlap_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one carrier step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds carriers at start phase and gates low |
| smp_valley | input | 1 | 1: strobe at carrier-A valley; 0: at carrier-A peak |
| duty_main_a | input | W | Branch A main-switch duty, 0..FULL |
| duty_div_a | input | W | Branch A diversion-switch duty, 0..FULL |
| duty_main_b | input | W | Branch B main-switch duty, 0..FULL |
| duty_div_b | input | W | Branch B diversion-switch duty, 0..FULL |
| duty_sel | input | W | Input-selection duty, 0..FULL |
| gate_main_a | output | 1 | Branch A main-switch gate |
| gate_div_a | output | 1 | Branch A diversion-switch gate |
| gate_main_b | output | 1 | Branch B main-switch gate |
| gate_div_b | output | 1 | Branch B diversion-switch gate |
| gate_sel | output | 1 | Input-selection switch gate |
| adc_strobe | output | 1 | One-clock ADC trigger at the chosen carrier-A extreme |
| overlap_err | output | 2 | Sticky duty-overlap flags, bit 0 branch A, bit 1 branch B |

W is $clog2(FULL+1).

## Verification
The hardest case to reach from the ports is a duty change in the middle of a period. It has to arrive after one carrier's valley but before the other carrier's valley, so that the bench can see which branch has already taken the new word. The bench changes the duty inputs at a chosen clock inside a running measurement window, five clocks after carrier B's valley. It counts the high clocks of every gate over that window and over the next one. The trimming case is reached by driving a pair whose sum exceeds full scale. The bench then shows that the flag outlives a legal pair and is cleared only by reset.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int unsigned CWIDTH = 16;

    typedef logic [CWIDTH-1:0] cword_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        logic main;
        logic div;
    } leg_t;

    typedef struct packed {
        cword_t main;
        cword_t div;
        logic   clip;
    } duty_pair_t;

    function automatic cword_t clamp_duty(cword_t d, cword_t full);
        return (d > full) ? full : d;
    endfunction

    // Clamp both words, then trim the diversion word so the pair fits.
    function automatic duty_pair_t fit_pair(cword_t m, cword_t v, cword_t full);
        duty_pair_t p;
        cword_t     mv;
        cword_t     vv;
        mv     = clamp_duty(m, full);
        vv     = clamp_duty(v, full);
        p.main = mv;
        p.clip = (mv > (full - vv));
        p.div  = p.clip ? (full - mv) : vv;
        return p;
    endfunction

    // Pulse centred on the valley: 2*duty steps per period.
    function automatic logic main_on(dir_e d, cword_t c, cword_t duty);
        return (d == DIR_UP) ? (c < duty) : (c <= duty);
    endfunction

    // Pulse centred on the peak: 2*duty steps per period.
    function automatic logic div_on(dir_e d, cword_t c, cword_t duty, cword_t full);
        return (d == DIR_UP) ? (c >= (full - duty)) : (c > (full - duty));
    endfunction

    // Half-height carrier compared at double resolution: duty steps per period.
    function automatic logic sel_on(dir_e d, cword_t c, cword_t duty);
        logic [CWIDTH:0] c2;
        logic [CWIDTH:0] dd;
        c2 = {c, 1'b0};
        dd = {1'b0, duty};
        return (d == DIR_UP) ? (c2 < dd) : (c2 <= dd);
    endfunction

endpackage

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
    import pwm3_pkg::*;
#(
    parameter int unsigned PEAK          = 1800,
    parameter int unsigned W             = 11,
    parameter bit          START_AT_PEAK = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         valley
);

    localparam logic [W-1:0] PK       = W'(PEAK);
    localparam logic [W-1:0] PKM1     = W'(PEAK - 1);
    localparam logic [W-1:0] ONE      = W'(1);
    localparam logic [W-1:0] INIT_CNT = START_AT_PEAK ? PK : '0;
    localparam dir_e         INIT_DIR = START_AT_PEAK ? DIR_DOWN : DIR_UP;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= INIT_CNT;
            dir <= INIT_DIR;
        end else if (dir == DIR_UP) begin
            cnt <= cnt + ONE;
            if (cnt == PKM1) dir <= DIR_DOWN;
        end else begin
            cnt <= cnt - ONE;
            if (cnt == ONE) dir <= DIR_UP;
        end
    end

    assign valley = (cnt == '0);

    // R1
    carrier_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= PK);

    // R1
    carrier_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == PK) |=> (cnt == PKM1));

endmodule

// File: rtl/pwm3_branch.sv
module pwm3_branch
    import pwm3_pkg::*;
#(
    parameter int unsigned FULL = 1800,
    parameter int unsigned W    = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  dir_e         dir,
    input  logic         valley,
    input  logic [W-1:0] duty_main,
    input  logic [W-1:0] duty_div,
    output leg_t         gates,
    output logic         overlap_err
);

    localparam cword_t FULL_C = cword_t'(FULL);

    duty_pair_t fit;
    cword_t     dm_q;
    cword_t     dd_q;
    logic       take;

    always_comb fit = fit_pair(cword_t'(duty_main), cword_t'(duty_div), FULL_C);

    assign take = !en || valley;

    always_ff @(posedge clk) begin
        if (rst) begin
            dm_q        <= '0;
            dd_q        <= '0;
            overlap_err <= 1'b0;
        end else if (take) begin
            dm_q <= fit.main;
            dd_q <= fit.div;
            if (fit.clip) overlap_err <= 1'b1;
        end
    end

    always_comb begin
        gates.main = en && main_on(dir, cword_t'(cnt), dm_q);
        gates.div  = en && div_on(dir, cword_t'(cnt), dd_q, FULL_C);
    end

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(gates.main && gates.div));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overlap_err |=> overlap_err);

    // R8
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !valley) |=> (dm_q == $past(dm_q) && dd_q == $past(dd_q)));

endmodule

// File: rtl/pwm3_modulator.sv
module pwm3_modulator
    import pwm3_pkg::*;
#(
    parameter int unsigned FULL = 1800,
    localparam int unsigned W   = $clog2(FULL + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         smp_valley,
    input  logic [W-1:0] duty_main_a,
    input  logic [W-1:0] duty_div_a,
    input  logic [W-1:0] duty_main_b,
    input  logic [W-1:0] duty_div_b,
    input  logic [W-1:0] duty_sel,
    output logic         gate_main_a,
    output logic         gate_div_a,
    output logic         gate_main_b,
    output logic         gate_div_b,
    output logic         gate_sel,
    output logic         adc_strobe,
    output logic [1:0]   overlap_err
);

    localparam int unsigned  HALF   = FULL / 2;
    localparam int unsigned  NCAR   = 3;
    localparam int unsigned  NLEG   = 2;
    localparam logic [W-1:0] FULL_W = W'(FULL);
    localparam cword_t       FULL_C = cword_t'(FULL);

    logic [W-1:0] c_cnt    [NCAR];
    dir_e         c_dir    [NCAR];
    logic         c_valley [NCAR];

    // Carrier 0: branch A, carrier 1: branch B (half period later), carrier 2: selection.
    for (genvar k = 0; k < NCAR; k++) begin : g_car
        pwm3_carrier #(
            .PEAK          ((k == 2) ? HALF : FULL),
            .W             (W),
            .START_AT_PEAK (k == 1)
        ) u_car (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .cnt    (c_cnt[k]),
            .dir    (c_dir[k]),
            .valley (c_valley[k])
        );
    end

    logic [W-1:0] dm_in [NLEG];
    logic [W-1:0] dd_in [NLEG];
    leg_t         legs  [NLEG];

    assign dm_in[0] = duty_main_a;
    assign dd_in[0] = duty_div_a;
    assign dm_in[1] = duty_main_b;
    assign dd_in[1] = duty_div_b;

    for (genvar b = 0; b < NLEG; b++) begin : g_leg
        pwm3_branch #(
            .FULL (FULL),
            .W    (W)
        ) u_leg (
            .clk         (clk),
            .rst         (rst),
            .en          (en),
            .cnt         (c_cnt[b]),
            .dir         (c_dir[b]),
            .valley      (c_valley[b]),
            .duty_main   (dm_in[b]),
            .duty_div    (dd_in[b]),
            .gates       (legs[b]),
            .overlap_err (overlap_err[b])
        );
    end

    assign gate_main_a = legs[0].main;
    assign gate_div_a  = legs[0].div;
    assign gate_main_b = legs[1].main;
    assign gate_div_b  = legs[1].div;

    cword_t ds_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ds_q <= '0;
        end else if (!en || c_valley[2]) begin
            ds_q <= clamp_duty(cword_t'(duty_sel), FULL_C);
        end
    end

    assign gate_sel   = en && sel_on(c_dir[2], cword_t'(c_cnt[2]), ds_q);
    assign adc_strobe = en && (smp_valley ? c_valley[0] : (c_cnt[0] == FULL_W));

    // R2
    carrier_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (en && c_valley[0]) |-> c_valley[2]);

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        adc_strobe |=> !adc_strobe);

    // R10
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_strobe && $past(en) && !$past(rst)) |->
            ($stable(gate_main_a) && $stable(gate_div_a) &&
             $stable(gate_main_b) && $stable(gate_div_b)));

endmodule

// File: tb/pwm3_modulator_bench.sv
`timescale 1ns/1ps
module pwm3_modulator_bench;

    localparam int unsigned FULL = 40;
    localparam int unsigned W    = $clog2(FULL + 1);
    localparam int          PER  = 2 * FULL;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic         smp_valley = 1'b0;
    logic [W-1:0] duty_main_a = '0;
    logic [W-1:0] duty_div_a  = '0;
    logic [W-1:0] duty_main_b = '0;
    logic [W-1:0] duty_div_b  = '0;
    logic [W-1:0] duty_sel    = '0;
    logic         gate_main_a, gate_div_a, gate_main_b, gate_div_b, gate_sel;
    logic         adc_strobe;
    logic [1:0]   overlap_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Results of one measurement window
    int hi_cnt [5];
    int ovl_n;
    int stb_n;
    int stb_idx;
    int stb_moved;
    int first_low_ma;
    int first_high_mb;
    int first_low_sel;

    always #2 clk = ~clk;

    pwm3_modulator #(.FULL(FULL)) u_pwm3_modulator (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .smp_valley  (smp_valley),
        .duty_main_a (duty_main_a),
        .duty_div_a  (duty_div_a),
        .duty_main_b (duty_main_b),
        .duty_div_b  (duty_div_b),
        .duty_sel    (duty_sel),
        .gate_main_a (gate_main_a),
        .gate_div_a  (gate_div_a),
        .gate_main_b (gate_main_b),
        .gate_div_b  (gate_div_b),
        .gate_sel    (gate_sel),
        .adc_strobe  (adc_strobe),
        .overlap_err (overlap_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_duty(input int ma, input int da, input int mb, input int db, input int s);
        duty_main_a = W'(ma);
        duty_div_a  = W'(da);
        duty_main_b = W'(mb);
        duty_div_b  = W'(db);
        duty_sel    = W'(s);
    endtask

    // Hold disabled for two edges so duties are taken, then enable at a falling edge.
    task automatic start_run();
        en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    task automatic stop_run();
        en = 1'b0;
        @(negedge clk);
    endtask

    // Sample PER consecutive clocks; optionally load new duties after sample chg_at.
    task automatic measure(input int chg_at, input int ma, input int da,
                           input int mb, input int db);
        logic [3:0] prev;
        logic [3:0] cur;
        prev = '0;
        for (int k = 0; k < 5; k++) hi_cnt[k] = 0;
        ovl_n = 0; stb_n = 0; stb_idx = -1; stb_moved = 0;
        first_low_ma = -1; first_high_mb = -1; first_low_sel = -1;
        for (int i = 0; i < PER; i++) begin
            #1;
            cur = {gate_main_a, gate_div_a, gate_main_b, gate_div_b};
            hi_cnt[0] += int'(gate_main_a);
            hi_cnt[1] += int'(gate_div_a);
            hi_cnt[2] += int'(gate_main_b);
            hi_cnt[3] += int'(gate_div_b);
            hi_cnt[4] += int'(gate_sel);
            if ((gate_main_a && gate_div_a) || (gate_main_b && gate_div_b)) ovl_n++;
            if (adc_strobe) begin
                stb_n++;
                stb_idx = i;
                if (i > 0 && cur != prev) stb_moved++;
            end
            if (first_low_ma < 0 && !gate_main_a) first_low_ma = i;
            if (first_high_mb < 0 && gate_main_b) first_high_mb = i;
            if (first_low_sel < 0 && !gate_sel) first_low_sel = i;
            prev = cur;
            if (i == chg_at) begin
                duty_main_a = W'(ma);
                duty_div_a  = W'(da);
                duty_main_b = W'(mb);
                duty_div_b  = W'(db);
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 reset gates", int'({gate_main_a, gate_div_a, gate_main_b, gate_div_b, gate_sel}), 0);
        chk("R11 reset strobe", int'(adc_strobe), 0);
        chk("R11 reset overlap_err", int'(overlap_err), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_basic();
        smp_valley = 1'b0;
        set_duty(10, 12, 14, 8, 10);
        start_run();
        measure(-1, 0, 0, 0, 0);
        chk("R3 main_a high clocks", hi_cnt[0], 20);
        chk("R3 div_a high clocks", hi_cnt[1], 24);
        chk("R3 main_b high clocks", hi_cnt[2], 28);
        chk("R3 div_b high clocks", hi_cnt[3], 16);
        chk("R4 sel high clocks", hi_cnt[4], 20);
        chk("R6 overlap clocks", ovl_n, 0);
        chk("R9 strobe count", stb_n, 1);
        chk("R9 strobe at peak", stb_idx, FULL);
        chk("R10 gates quiet at strobe", stb_moved, 0);
        // Carrier A rises from 0: main_a low from clock Dm on.
        chk("R1 carrier A phase", first_low_ma, 10);
        // Carrier B falls from FULL: main_b rises when FULL-i <= 14.
        chk("R1 carrier B half-period shift", first_high_mb, FULL - 14);
        // Selection carrier rises from 0 with carrier A: low once 2*i >= 10.
        chk("R2 selection carrier alignment", first_low_sel, 5);
        chk("R7 no clip flag", int'(overlap_err), 0);
        stop_run();
    endtask

    task automatic t_bounds();
        smp_valley = 1'b1;
        set_duty(0, FULL, FULL, 0, FULL);
        start_run();
        measure(-1, 0, 0, 0, 0);
        chk("R5 duty 0 main_a", hi_cnt[0], 0);
        chk("R5 duty FULL div_a", hi_cnt[1], PER);
        chk("R5 duty FULL main_b", hi_cnt[2], PER);
        chk("R5 duty 0 div_b", hi_cnt[3], 0);
        chk("R5 duty FULL sel", hi_cnt[4], PER);
        chk("R9 strobe at valley", stb_idx, 0);
        chk("R9 strobe count valley", stb_n, 1);
        stop_run();
        set_duty((1 << W) - 1, 0, 0, (1 << W) - 1, (1 << W) - 1);
        start_run();
        measure(-1, 0, 0, 0, 0);
        chk("R5 saturated main_a", hi_cnt[0], PER);
        chk("R5 saturated div_b", hi_cnt[3], PER);
        chk("R5 saturated sel", hi_cnt[4], PER);
        chk("R5 no flag from saturation", int'(overlap_err), 0);
        stop_run();
        // Odd selection duty
        set_duty(0, 0, 0, 0, 7);
        start_run();
        measure(-1, 0, 0, 0, 0);
        chk("R4 odd selection duty", hi_cnt[4], 14);
        stop_run();
    endtask

    task automatic t_clip();
        smp_valley = 1'b0;
        set_duty(30, 20, 5, 5, 0);
        start_run();
        measure(-1, 0, 0, 0, 0);
        chk("R7 trimmed div_a", hi_cnt[1], 2 * (FULL - 30));
        chk("R7 main_a kept", hi_cnt[0], 60);
        chk("R6 overlap under clip", ovl_n, 0);
        chk("R7 flag branch A only", int'(overlap_err), 1);
        stop_run();
        set_duty(30, 5, 5, 5, 0);
        start_run();
        measure(-1, 0, 0, 0, 0);
        chk("R7 legal pair div_a", hi_cnt[1], 10);
        chk("R7 flag sticky", int'(overlap_err), 1);
        stop_run();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 reset clears flag", int'(overlap_err), 0);
        @(negedge clk);
    endtask

    task automatic t_update();
        smp_valley = 1'b0;
        set_duty(10, 10, 10, 10, 10);
        start_run();
        // Change five clocks after carrier B's valley (clock FULL).
        measure(FULL + 5, 20, 4, 20, 4);
        chk("R8 main_a keeps old duty", hi_cnt[0], 20);
        chk("R8 div_a keeps old duty", hi_cnt[1], 20);
        chk("R8 main_b keeps old duty", hi_cnt[2], 20);
        chk("R8 div_b keeps old duty", hi_cnt[3], 20);
        measure(-1, 0, 0, 0, 0);
        chk("R8 main_a new duty", hi_cnt[0], 40);
        chk("R8 div_a new duty", hi_cnt[1], 8);
        stop_run();
    endtask

    task automatic t_disable();
        smp_valley = 1'b1;
        set_duty(10, 10, 10, 10, 10);
        start_run();
        repeat (13) @(negedge clk);
        en = 1'b0;
        #1;
        chk("R11 gates low when disabled",
            int'({gate_main_a, gate_div_a, gate_main_b, gate_div_b, gate_sel}), 0);
        chk("R11 strobe low when disabled", int'(adc_strobe), 0);
        repeat (3) @(negedge clk);
        en = 1'b1;
        measure(-1, 0, 0, 0, 0);
        chk("R11 restart strobe phase", stb_idx, 0);
        chk("R11 restart main_a phase", first_low_ma, 10);
        stop_run();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_bounds();
        t_clip();
        t_update();
        t_disable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule